// File: doc/BRIEF.md
# DRAM Controller User Command Front End

This block sits between user logic and the scheduling core of a simple DRAM controller. User logic hands it read and write commands carrying a flat address, using a valid/ready handshake. Write data words arrive on a separate handshake, each with a per-byte mask and an end-of-burst marker. A burst's data may arrive before its command, or up to two cycles after it. The block queues commands and data separately. It forwards a write command downstream only after the whole data burst for that command is held locally. Once the command is accepted downstream, the block streams that burst downstream on the following cycles.

Each flat address is split into bank, row and column fields when the command is accepted. The field order is chosen at build time. Every accepted read gets a tag. Read responses may come back from downstream in any tag order; a reorder buffer collects them and releases them to the user in the order the reads were accepted. Each returned word carries a valid flag, and a last flag marks the final word of each burst.

Top module: `dram_user_front`

## Requirements
- R1: A command is taken only on a rising edge where `usr_cmd_en` and `usr_cmd_rdy` are both high. `usr_cmd_rdy` is low while the command queue holds CMDQ_DEPTH entries, and also while all 2^TAG_W read slots are in use. A command offered while ready is low leaves no trace downstream.
- R2: A write data word is taken only on an edge where `usr_wd_en` and `usr_wd_rdy` are both high. `usr_wd_rdy` is low while the data queue holds WDQ_DEPTH words. Words offered while ready is low are never forwarded.
- R3: A complete data burst may be pushed before its write command. That write is then forwarded with that burst.
- R4: A burst whose end-marked word arrives within two cycles after its write command is accepted is paired with that command.
- R5: A write command is presented downstream (`dn_req_valid`) only once a full end-marked burst is queued. The burst's words appear on `dn_wd_valid` in consecutive cycles, starting the cycle after the write request handshake. No request is presented while a burst is streaming.
- R6: Data, byte mask and end marker of each write word reach the downstream port unchanged and in push order.
- R7: With ADDR_ORDER = ORDER_BRC (default), the flat address splits as bank = addr[27:25], row = addr[24:10], col = addr[9:0].
- R8: With ADDR_ORDER = ORDER_RBC, the flat address splits as row = addr[27:13], bank = addr[12:10], col = addr[9:0].
- R9: Read tags are given out in acceptance order, starting at 0 after reset and counting up modulo 2^TAG_W. Read data reaches the user strictly in acceptance order, whatever the order of the downstream responses. Nothing is returned before the oldest read's burst is complete.
- R10: Each returned read word has `usr_rd_valid` high. The words of one burst come in consecutive cycles, and `usr_rd_last` is high on the final word only.
- R11: After reset, both user ready outputs are high. `dn_req_valid`, `dn_wd_valid` and `usr_rd_valid` are low.
- R12: Commands leave on the downstream port in the order they were accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| usr_cmd_en | input | 1 | Command offered |
| usr_cmd_wr | input | 1 | 1 = write, 0 = read |
| usr_addr | input | ADDR_W | Flat address |
| usr_cmd_rdy | output | 1 | Command can be taken |
| usr_wd_en | input | 1 | Write data word offered |
| usr_wd_data | input | DATA_W | Write data |
| usr_wd_mask | input | MASK_W | 1 = do not write this byte |
| usr_wd_last | input | 1 | Final word of the burst |
| usr_wd_rdy | output | 1 | Data word can be taken |
| usr_rd_valid | output | 1 | Read word valid |
| usr_rd_data | output | DATA_W | Read data |
| usr_rd_last | output | 1 | Final word of the read burst |
| dn_req_valid | output | 1 | Downstream request valid |
| dn_req_ready | input | 1 | Downstream takes the request |
| dn_req_wr | output | 1 | Request is a write |
| dn_req_bank | output | BANK_W | Bank field |
| dn_req_row | output | ROW_W | Row field |
| dn_req_col | output | COL_W | Column field |
| dn_req_tag | output | TAG_W | Read tag |
| dn_wd_valid | output | 1 | Downstream write word valid |
| dn_wd_data | output | DATA_W | Downstream write data |
| dn_wd_mask | output | MASK_W | Downstream byte mask |
| dn_wd_last | output | 1 | Final downstream word |
| dn_rsp_valid | input | 1 | Read response word valid |
| dn_rsp_tag | input | TAG_W | Tag of the response word |
| dn_rsp_data | input | DATA_W | Response data |
| dn_rsp_last | input | 1 | Final response word for the tag |

## Verification
Writes are tried in three patterns. In the first, data leads the command. In the second, data trails the command by one and two cycles, which shows whether the request is held back until the burst is complete. In the third, both queues are filled to capacity while downstream stalls, which shows whether offers made while ready is low are dropped and whether order is kept. Reads are tried with a single in-order response and with four outstanding reads whose responses come back reversed and interleaved. This separates true reordering from pass-through, and it exercises the slot limit on command ready. A second instance built with the other field order receives the same address, so the two splits can be compared directly.

// File: rtl/dfe_pkg.sv
package dfe_pkg;
    typedef enum logic {
        ORDER_BRC,
        ORDER_RBC
    } addr_order_e;

    typedef enum logic {
        PH_IDLE,
        PH_STREAM
    } phase_e;
endpackage

// File: rtl/dfe_fifo.sv
module dfe_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic             full,
    output logic             empty
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [PW-1:0] wp;
        logic [PW-1:0] rp;
        logic [CW-1:0] cnt;
    } ptr_t;

    ptr_t s_d, s_q;
    logic [WIDTH-1:0] mem_q [DEPTH];
    logic do_push, do_pop;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full    = (s_q.cnt == CW'(DEPTH));
    assign empty   = (s_q.cnt == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem_q[s_q.rp];

    always_comb begin
        s_d = s_q;
        if (do_push) s_d.wp = bump(s_q.wp);
        if (do_pop)  s_d.rp = bump(s_q.rp);
        s_d.cnt = s_q.cnt + CW'(do_push) - CW'(do_pop);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem_q[s_q.wp] <= din;
    end
endmodule

// File: rtl/dfe_addr_split.sv
module dfe_addr_split
    import dfe_pkg::*;
#(
    parameter int          ROW_W  = 15,
    parameter int          BANK_W = 3,
    parameter int          COL_W  = 10,
    parameter addr_order_e ORDER  = ORDER_BRC,
    localparam int         ADDR_W = ROW_W + BANK_W + COL_W
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [BANK_W-1:0] bank,
    output logic [ROW_W-1:0]  row,
    output logic [COL_W-1:0]  col
);
    // Column always occupies the low bits; the order of the upper two fields
    // is fixed at build time.
    assign col = addr[COL_W-1:0];

    generate
        if (ORDER == ORDER_BRC) begin : g_brc
            assign row  = addr[COL_W +: ROW_W];
            assign bank = addr[COL_W + ROW_W +: BANK_W];
        end else begin : g_rbc
            assign bank = addr[COL_W +: BANK_W];
            assign row  = addr[COL_W + BANK_W +: ROW_W];
        end
    endgenerate
endmodule

// File: rtl/dfe_rob.sv
module dfe_rob #(
    parameter int DATA_W = 32,
    parameter int TAG_W  = 2,
    parameter int BEATS  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc,
    output logic              avail,
    output logic [TAG_W-1:0]  alloc_tag,
    input  logic              rsp_valid,
    input  logic [TAG_W-1:0]  rsp_tag,
    input  logic [DATA_W-1:0] rsp_data,
    input  logic              rsp_last,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              out_last
);
    localparam int NTAG = 1 << TAG_W;
    localparam int BW   = (BEATS > 1) ? $clog2(BEATS) : 1;
    localparam int UW   = $clog2(NTAG + 1);

    typedef struct packed {
        logic [TAG_W-1:0]          head;
        logic [TAG_W-1:0]          tail;
        logic [UW-1:0]             used;
        logic [BW-1:0]             obeat;
        logic [NTAG-1:0]           done;
        logic [NTAG-1:0][BW-1:0]   wcnt;
        logic [NTAG-1:0][BW-1:0]   lastidx;
    } rob_t;

    rob_t s_d, s_q;
    logic [DATA_W-1:0] mem_q [NTAG][BEATS];
    logic free;

    assign avail     = (s_q.used != UW'(NTAG));
    assign alloc_tag = s_q.tail;
    assign out_valid = s_q.done[s_q.head];
    assign out_data  = mem_q[s_q.head][s_q.obeat];
    assign out_last  = out_valid && (s_q.obeat == s_q.lastidx[s_q.head]);

    always_comb begin
        s_d  = s_q;
        free = 1'b0;
        if (alloc && avail) s_d.tail = s_q.tail + 1'b1;
        if (rsp_valid) begin
            if (rsp_last) begin
                s_d.done[rsp_tag]    = 1'b1;
                s_d.lastidx[rsp_tag] = s_q.wcnt[rsp_tag];
                s_d.wcnt[rsp_tag]    = '0;
            end else begin
                s_d.wcnt[rsp_tag] = s_q.wcnt[rsp_tag] + 1'b1;
            end
        end
        if (out_valid) begin
            if (out_last) begin
                s_d.done[s_q.head] = 1'b0;
                s_d.head           = s_q.head + 1'b1;
                s_d.obeat          = '0;
                free               = 1'b1;
            end else begin
                s_d.obeat = s_q.obeat + 1'b1;
            end
        end
        s_d.used = s_q.used + UW'(alloc && avail) - UW'(free);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_ff @(posedge clk) begin
        if (rsp_valid) mem_q[rsp_tag][s_q.wcnt[rsp_tag]] <= rsp_data;
    end
endmodule

// File: rtl/dram_user_front.sv
module dram_user_front
    import dfe_pkg::*;
#(
    parameter int          ROW_W       = 15,
    parameter int          BANK_W      = 3,
    parameter int          COL_W       = 10,
    parameter int          DATA_W      = 32,
    parameter int          CMDQ_DEPTH  = 4,
    parameter int          WDQ_DEPTH   = 8,
    parameter int          TAG_W       = 2,
    parameter int          BURST_WORDS = 2,
    parameter addr_order_e ADDR_ORDER  = ORDER_BRC,
    localparam int         ADDR_W      = ROW_W + BANK_W + COL_W,
    localparam int         MASK_W      = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              usr_cmd_en,
    input  logic              usr_cmd_wr,
    input  logic [ADDR_W-1:0] usr_addr,
    output logic              usr_cmd_rdy,
    input  logic              usr_wd_en,
    input  logic [DATA_W-1:0] usr_wd_data,
    input  logic [MASK_W-1:0] usr_wd_mask,
    input  logic              usr_wd_last,
    output logic              usr_wd_rdy,
    output logic              usr_rd_valid,
    output logic [DATA_W-1:0] usr_rd_data,
    output logic              usr_rd_last,
    output logic              dn_req_valid,
    input  logic              dn_req_ready,
    output logic              dn_req_wr,
    output logic [BANK_W-1:0] dn_req_bank,
    output logic [ROW_W-1:0]  dn_req_row,
    output logic [COL_W-1:0]  dn_req_col,
    output logic [TAG_W-1:0]  dn_req_tag,
    output logic              dn_wd_valid,
    output logic [DATA_W-1:0] dn_wd_data,
    output logic [MASK_W-1:0] dn_wd_mask,
    output logic              dn_wd_last,
    input  logic              dn_rsp_valid,
    input  logic [TAG_W-1:0]  dn_rsp_tag,
    input  logic [DATA_W-1:0] dn_rsp_data,
    input  logic              dn_rsp_last
);
    localparam int BCW = $clog2(WDQ_DEPTH + 1);

    typedef struct packed {
        logic              wr;
        logic [BANK_W-1:0] bank;
        logic [ROW_W-1:0]  row;
        logic [COL_W-1:0]  col;
        logic [TAG_W-1:0]  tag;
    } cmd_t;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic [MASK_W-1:0] mask;
        logic              last;
    } word_t;

    typedef struct packed {
        phase_e         phase;
        logic [BCW-1:0] bursts;   // complete end-marked bursts held in the data queue
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [BANK_W-1:0] sp_bank;
    logic [ROW_W-1:0]  sp_row;
    logic [COL_W-1:0]  sp_col;
    cmd_t  cq_in, cq_out;
    word_t wq_in, wq_out;
    logic  cq_full, cq_empty, cq_pop;
    logic  wq_full, wq_empty, wq_pop;
    logic  rob_avail;
    logic [TAG_W-1:0] rob_tag;
    logic  cmd_take, wd_take;

    dfe_addr_split #(
        .ROW_W (ROW_W),
        .BANK_W(BANK_W),
        .COL_W (COL_W),
        .ORDER (ADDR_ORDER)
    ) u_split (
        .addr(usr_addr),
        .bank(sp_bank),
        .row (sp_row),
        .col (sp_col)
    );

    // Command acceptance
    assign usr_cmd_rdy = !cq_full && rob_avail;
    assign cmd_take    = usr_cmd_en && usr_cmd_rdy;

    always_comb begin
        cq_in.wr   = usr_cmd_wr;
        cq_in.bank = sp_bank;
        cq_in.row  = sp_row;
        cq_in.col  = sp_col;
        cq_in.tag  = usr_cmd_wr ? '0 : rob_tag;
    end

    dfe_fifo #(
        .WIDTH($bits(cmd_t)),
        .DEPTH(CMDQ_DEPTH)
    ) u_cmdq (
        .clk  (clk),
        .rst_n(rst_n),
        .push (cmd_take),
        .din  (cq_in),
        .pop  (cq_pop),
        .dout (cq_out),
        .full (cq_full),
        .empty(cq_empty)
    );

    // Write data acceptance
    assign usr_wd_rdy = !wq_full;
    assign wd_take    = usr_wd_en && usr_wd_rdy;

    always_comb begin
        wq_in.data = usr_wd_data;
        wq_in.mask = usr_wd_mask;
        wq_in.last = usr_wd_last;
    end

    dfe_fifo #(
        .WIDTH($bits(word_t)),
        .DEPTH(WDQ_DEPTH)
    ) u_wdq (
        .clk  (clk),
        .rst_n(rst_n),
        .push (wd_take),
        .din  (wq_in),
        .pop  (wq_pop),
        .dout (wq_out),
        .full (wq_full),
        .empty(wq_empty)
    );

    // Issue and pairing control
    always_comb begin
        ctl_d        = ctl_q;
        dn_req_valid = 1'b0;
        dn_wd_valid  = 1'b0;
        cq_pop       = 1'b0;
        wq_pop       = 1'b0;
        case (ctl_q.phase)
            PH_IDLE: begin
                dn_req_valid = !cq_empty && (!cq_out.wr || (ctl_q.bursts != '0));
                if (dn_req_valid && dn_req_ready) begin
                    cq_pop = 1'b1;
                    if (cq_out.wr) ctl_d.phase = PH_STREAM;
                end
            end
            PH_STREAM: begin
                dn_wd_valid = !wq_empty;
                wq_pop      = dn_wd_valid;
                if (dn_wd_valid && wq_out.last) ctl_d.phase = PH_IDLE;
            end
            default: ctl_d.phase = PH_IDLE;
        endcase
        ctl_d.bursts = ctl_q.bursts + BCW'(wd_take && usr_wd_last)
                                    - BCW'(dn_wd_valid && wq_out.last);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.phase  <= PH_IDLE;
            ctl_q.bursts <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign dn_req_wr   = cq_out.wr;
    assign dn_req_bank = cq_out.bank;
    assign dn_req_row  = cq_out.row;
    assign dn_req_col  = cq_out.col;
    assign dn_req_tag  = cq_out.tag;
    assign dn_wd_data  = wq_out.data;
    assign dn_wd_mask  = wq_out.mask;
    assign dn_wd_last  = wq_out.last;

    // In-order read return
    dfe_rob #(
        .DATA_W(DATA_W),
        .TAG_W (TAG_W),
        .BEATS (BURST_WORDS)
    ) u_rob (
        .clk      (clk),
        .rst_n    (rst_n),
        .alloc    (cmd_take && !usr_cmd_wr),
        .avail    (rob_avail),
        .alloc_tag(rob_tag),
        .rsp_valid(dn_rsp_valid),
        .rsp_tag  (dn_rsp_tag),
        .rsp_data (dn_rsp_data),
        .rsp_last (dn_rsp_last),
        .out_valid(usr_rd_valid),
        .out_data (usr_rd_data),
        .out_last (usr_rd_last)
    );
endmodule

// File: rtl/dfe_checker.sv
module dfe_checker (
    input logic clk,
    input logic rst_n,
    input logic usr_cmd_en,
    input logic usr_cmd_rdy,
    input logic usr_cmd_wr,
    input logic usr_wd_en,
    input logic usr_wd_rdy,
    input logic usr_wd_last,
    input logic usr_rd_valid,
    input logic usr_rd_last,
    input logic dn_req_valid,
    input logic dn_req_ready,
    input logic dn_req_wr,
    input logic dn_wd_valid,
    input logic dn_wd_last
);
    // Write commands accepted minus end-marked bursts accepted, and how long
    // that balance has stayed positive.
    logic signed [7:0] gap_q;
    logic [2:0]        age_q;
    logic wr_take, burst_take;

    assign wr_take    = usr_cmd_en && usr_cmd_rdy && usr_cmd_wr;
    assign burst_take = usr_wd_en && usr_wd_rdy && usr_wd_last;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q <= '0;
            age_q <= '0;
        end else begin
            gap_q <= gap_q + $signed({7'd0, wr_take}) - $signed({7'd0, burst_take});
            if (gap_q > 8'sd0) age_q <= (age_q == 3'd7) ? age_q : age_q + 3'd1;
            else               age_q <= '0;
        end
    end

    p_wdata_late_r4: assert property (@(posedge clk) disable iff (!rst_n)
        age_q <= 3'd2);

    p_stream_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_req_valid && dn_req_ready && dn_req_wr) |=> dn_wd_valid);

    p_stream_contig_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_wd_valid && !dn_wd_last) |=> dn_wd_valid);

    p_no_req_in_stream_r5: assert property (@(posedge clk) disable iff (!rst_n)
        dn_wd_valid |-> !dn_req_valid);

    p_rd_contig_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (usr_rd_valid && !usr_rd_last) |=> usr_rd_valid);
endmodule

bind dram_user_front dfe_checker u_chk (.*);

// File: tb/dram_user_front_test.sv
`timescale 1ns/1ps
module dram_user_front_test;
    import dfe_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic        usr_cmd_en = 0, usr_cmd_wr = 0;
    logic [27:0] usr_addr = '0;
    logic        usr_cmd_rdy;
    logic        usr_wd_en = 0, usr_wd_last = 0;
    logic [31:0] usr_wd_data = '0;
    logic [3:0]  usr_wd_mask = '0;
    logic        usr_wd_rdy;
    logic        usr_rd_valid, usr_rd_last;
    logic [31:0] usr_rd_data;
    logic        dn_req_valid, dn_req_ready = 0, dn_req_wr;
    logic [2:0]  dn_req_bank;
    logic [14:0] dn_req_row;
    logic [9:0]  dn_req_col;
    logic [1:0]  dn_req_tag;
    logic        dn_wd_valid, dn_wd_last;
    logic [31:0] dn_wd_data;
    logic [3:0]  dn_wd_mask;
    logic        dn_rsp_valid = 0, dn_rsp_last = 0;
    logic [1:0]  dn_rsp_tag = '0;
    logic [31:0] dn_rsp_data = '0;

    // second build with the other field order; only its split is checked
    logic        b_cmd_rdy, b_wd_rdy, b_rd_valid, b_rd_last, b_req_valid, b_req_wr;
    logic        b_wd_valid, b_wd_last;
    logic [31:0] b_rd_data, b_wd_data;
    logic [3:0]  b_wd_mask;
    logic [2:0]  b_bank;
    logic [14:0] b_row;
    logic [9:0]  b_col;
    logic [1:0]  b_tag;

    dram_user_front uut (
        .clk(clk), .rst_n(rst_n),
        .usr_cmd_en(usr_cmd_en), .usr_cmd_wr(usr_cmd_wr), .usr_addr(usr_addr),
        .usr_cmd_rdy(usr_cmd_rdy),
        .usr_wd_en(usr_wd_en), .usr_wd_data(usr_wd_data), .usr_wd_mask(usr_wd_mask),
        .usr_wd_last(usr_wd_last), .usr_wd_rdy(usr_wd_rdy),
        .usr_rd_valid(usr_rd_valid), .usr_rd_data(usr_rd_data), .usr_rd_last(usr_rd_last),
        .dn_req_valid(dn_req_valid), .dn_req_ready(dn_req_ready), .dn_req_wr(dn_req_wr),
        .dn_req_bank(dn_req_bank), .dn_req_row(dn_req_row), .dn_req_col(dn_req_col),
        .dn_req_tag(dn_req_tag),
        .dn_wd_valid(dn_wd_valid), .dn_wd_data(dn_wd_data), .dn_wd_mask(dn_wd_mask),
        .dn_wd_last(dn_wd_last),
        .dn_rsp_valid(dn_rsp_valid), .dn_rsp_tag(dn_rsp_tag), .dn_rsp_data(dn_rsp_data),
        .dn_rsp_last(dn_rsp_last)
    );

    dram_user_front #(.ADDR_ORDER(ORDER_RBC)) uut_rbc (
        .clk(clk), .rst_n(rst_n),
        .usr_cmd_en(usr_cmd_en), .usr_cmd_wr(usr_cmd_wr), .usr_addr(usr_addr),
        .usr_cmd_rdy(b_cmd_rdy),
        .usr_wd_en(usr_wd_en), .usr_wd_data(usr_wd_data), .usr_wd_mask(usr_wd_mask),
        .usr_wd_last(usr_wd_last), .usr_wd_rdy(b_wd_rdy),
        .usr_rd_valid(b_rd_valid), .usr_rd_data(b_rd_data), .usr_rd_last(b_rd_last),
        .dn_req_valid(b_req_valid), .dn_req_ready(dn_req_ready), .dn_req_wr(b_req_wr),
        .dn_req_bank(b_bank), .dn_req_row(b_row), .dn_req_col(b_col), .dn_req_tag(b_tag),
        .dn_wd_valid(b_wd_valid), .dn_wd_data(b_wd_data), .dn_wd_mask(b_wd_mask),
        .dn_wd_last(b_wd_last),
        .dn_rsp_valid(dn_rsp_valid), .dn_rsp_tag(dn_rsp_tag), .dn_rsp_data(dn_rsp_data),
        .dn_rsp_last(dn_rsp_last)
    );

    int checks = 0;
    int errors = 0;

    // logs filled by the monitor, 1 ns before each rising edge
    logic [30:0] req_log [64];
    logic [36:0] wd_log  [64];
    logic [32:0] rd_log  [64];
    int n_req = 0, n_wd = 0, n_rd = 0;

    always begin
        @(negedge clk);
        #4;
        if (rst_n) begin
            if (dn_req_valid && dn_req_ready) begin
                req_log[n_req] = {dn_req_wr, dn_req_bank, dn_req_row, dn_req_col, dn_req_tag};
                n_req++;
            end
            if (dn_wd_valid) begin
                wd_log[n_wd] = {dn_wd_data, dn_wd_mask, dn_wd_last};
                n_wd++;
            end
            if (usr_rd_valid) begin
                rd_log[n_rd] = {usr_rd_data, usr_rd_last};
                n_rd++;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // all drivers are entered and left at a falling edge
    task automatic send_cmd(input logic wr, input logic [27:0] a);
        bit took;
        usr_cmd_en = 1; usr_cmd_wr = wr; usr_addr = a;
        do begin
            #4; took = usr_cmd_rdy;
            @(negedge clk);
        end while (!took);
        usr_cmd_en = 0;
    endtask

    task automatic send_word(input logic [31:0] d, input logic [3:0] m, input logic l);
        bit took;
        usr_wd_en = 1; usr_wd_data = d; usr_wd_mask = m; usr_wd_last = l;
        do begin
            #4; took = usr_wd_rdy;
            @(negedge clk);
        end while (!took);
        usr_wd_en = 0;
    endtask

    task automatic rsp_word(input logic [1:0] t, input logic [31:0] d, input logic l);
        dn_rsp_valid = 1; dn_rsp_tag = t; dn_rsp_data = d; dn_rsp_last = l;
        @(negedge clk);
        dn_rsp_valid = 0;
    endtask

    task automatic t_reset;
        chk(usr_cmd_rdy === 1'b1, "R11 cmd_rdy", 64'(usr_cmd_rdy), 1);
        chk(usr_wd_rdy === 1'b1, "R11 wd_rdy", 64'(usr_wd_rdy), 1);
        chk(dn_req_valid === 1'b0, "R11 req_valid", 64'(dn_req_valid), 0);
        chk(dn_wd_valid === 1'b0, "R11 wd_valid", 64'(dn_wd_valid), 0);
        chk(usr_rd_valid === 1'b0, "R11 rd_valid", 64'(usr_rd_valid), 0);
    endtask

    task automatic t_read_split;
        logic [27:0] a;
        int rb;
        a = {3'd5, 15'h1234, 10'h2AB};
        rb = n_rd;
        dn_req_ready = 0;
        send_cmd(0, a);
        chk(dn_req_valid === 1'b1 && dn_req_wr === 1'b0, "R7 read presented",
            64'({dn_req_valid, dn_req_wr}), 64'b10);
        chk(dn_req_bank === a[27:25], "R7 bank", 64'(dn_req_bank), 64'(a[27:25]));
        chk(dn_req_row === a[24:10], "R7 row", 64'(dn_req_row), 64'(a[24:10]));
        chk(dn_req_col === a[9:0], "R7 col", 64'(dn_req_col), 64'(a[9:0]));
        chk(dn_req_tag === 2'd0, "R9 first tag", 64'(dn_req_tag), 0);
        chk(b_row === a[27:13], "R8 row", 64'(b_row), 64'(a[27:13]));
        chk(b_bank === a[12:10], "R8 bank", 64'(b_bank), 64'(a[12:10]));
        chk(b_col === a[9:0], "R8 col", 64'(b_col), 64'(a[9:0]));
        dn_req_ready = 1;
        idle(1);
        rsp_word(2'd0, 32'hA0A0_0001, 0);
        rsp_word(2'd0, 32'hA0A0_0002, 1);
        idle(4);
        chk(n_rd == rb + 2, "R10 word count", 64'(n_rd - rb), 2);
        chk(rd_log[rb] === {32'hA0A0_0001, 1'b0}, "R10 first word",
            64'(rd_log[rb]), {32'hA0A0_0001, 1'b0});
        chk(rd_log[rb+1] === {32'hA0A0_0002, 1'b1}, "R10 last word",
            64'(rd_log[rb+1]), {32'hA0A0_0002, 1'b1});
    endtask

    task automatic t_write_before;
        int qb, wb;
        logic [27:0] a;
        a = {3'd2, 15'h0F0F, 10'h011};
        qb = n_req; wb = n_wd;
        dn_req_ready = 1;
        send_word(32'h1111_0001, 4'b0001, 0);
        send_word(32'h1111_0002, 4'b1000, 1);
        idle(2);
        chk(n_wd == wb, "R5 data held without command", 64'(n_wd - wb), 0);
        send_cmd(1, a);
        idle(5);
        chk(n_req == qb + 1, "R3 write forwarded", 64'(n_req - qb), 1);
        chk(req_log[qb] === {1'b1, a[27:25], a[24:10], a[9:0], 2'd0}, "R3 write request",
            64'(req_log[qb]), {1'b1, a[27:25], a[24:10], a[9:0], 2'd0});
        chk(wd_log[wb] === {32'h1111_0001, 4'b0001, 1'b0}, "R6 word 0",
            64'(wd_log[wb]), {32'h1111_0001, 4'b0001, 1'b0});
        chk(wd_log[wb+1] === {32'h1111_0002, 4'b1000, 1'b1}, "R6 word 1",
            64'(wd_log[wb+1]), {32'h1111_0002, 4'b1000, 1'b1});
    endtask

    task automatic t_write_after;
        int wb;
        wb = n_wd;
        dn_req_ready = 1;
        send_cmd(1, {3'd7, 15'h0002, 10'h3FF});
        chk(dn_req_valid === 1'b0, "R5 no request before data", 64'(dn_req_valid), 0);
        send_word(32'h2222_0001, 4'b0110, 0);
        chk(dn_req_valid === 1'b0, "R5 no request on partial burst", 64'(dn_req_valid), 0);
        send_word(32'h2222_0002, 4'b0000, 1);
        chk(dn_req_valid === 1'b1, "R4 request once burst complete", 64'(dn_req_valid), 1);
        idle(4);
        chk(n_wd == wb + 2, "R4 trailing burst streamed", 64'(n_wd - wb), 2);
        chk(wd_log[wb+1] === {32'h2222_0002, 4'b0000, 1'b1}, "R6 trailing last word",
            64'(wd_log[wb+1]), {32'h2222_0002, 4'b0000, 1'b1});
    endtask

    task automatic t_queue_full;
        int qb, wb;
        logic [27:0] a;
        qb = n_req; wb = n_wd;
        dn_req_ready = 0;
        for (int i = 0; i < 8; i++)
            send_word(32'h3300_0000 + 32'(i), 4'(i), 1'((i % 2) == 1));
        chk(usr_wd_rdy === 1'b0, "R2 data queue full", 64'(usr_wd_rdy), 0);
        usr_wd_en = 1; usr_wd_data = 32'hDEAD_BEEF; usr_wd_mask = 4'hF; usr_wd_last = 1;
        idle(3);
        usr_wd_en = 0;
        for (int k = 0; k < 4; k++) send_cmd(1, {3'(k), 15'(k + 100), 10'(k)});
        chk(usr_cmd_rdy === 1'b0, "R1 command queue full", 64'(usr_cmd_rdy), 0);
        usr_cmd_en = 1; usr_cmd_wr = 1; usr_addr = 28'hFFF_FFFF;
        idle(3);
        usr_cmd_en = 0;
        dn_req_ready = 1;
        idle(20);
        chk(n_req == qb + 4, "R1 offer while not ready ignored", 64'(n_req - qb), 4);
        chk(n_wd == wb + 8, "R2 offer while not ready ignored", 64'(n_wd - wb), 8);
        for (int k = 0; k < 4; k++) begin
            a = {3'(k), 15'(k + 100), 10'(k)};
            chk(req_log[qb+k] === {1'b1, a[27:25], a[24:10], a[9:0], 2'd0}, "R12 order",
                64'(req_log[qb+k]), {1'b1, a[27:25], a[24:10], a[9:0], 2'd0});
        end
        for (int i = 0; i < 8; i++)
            chk(wd_log[wb+i] === {32'h3300_0000 + 32'(i), 4'(i), 1'((i % 2) == 1)},
                "R6 word order", 64'(wd_log[wb+i]),
                {32'h3300_0000 + 32'(i), 4'(i), 1'((i % 2) == 1)});
    endtask

    function automatic logic [31:0] rdat(input int idx, input int beat);
        return 32'hC0DE_0000 + 32'(idx * 16 + beat);
    endfunction

    task automatic t_read_reorder;
        int qb, rb;
        logic [1:0] tg [4];
        qb = n_req; rb = n_rd;
        dn_req_ready = 1;
        for (int k = 0; k < 4; k++) send_cmd(0, {3'd1, 15'(k), 10'(k * 8)});
        idle(1);
        chk(usr_cmd_rdy === 1'b0, "R1 all read slots used", 64'(usr_cmd_rdy), 0);
        chk(n_req == qb + 4, "R9 reads issued", 64'(n_req - qb), 4);
        for (int k = 0; k < 4; k++) begin
            tg[k] = req_log[qb+k][1:0];
            chk(tg[k] === 2'(k + 1), "R9 tag sequence", 64'(tg[k]), 64'(k + 1));
        end
        rsp_word(tg[3], rdat(3, 0), 0);
        rsp_word(tg[2], rdat(2, 0), 0);
        rsp_word(tg[3], rdat(3, 1), 1);
        rsp_word(tg[1], rdat(1, 0), 0);
        rsp_word(tg[1], rdat(1, 1), 1);
        rsp_word(tg[2], rdat(2, 1), 1);
        idle(2);
        chk(n_rd == rb, "R9 held until oldest complete", 64'(n_rd - rb), 0);
        rsp_word(tg[0], rdat(0, 0), 0);
        rsp_word(tg[0], rdat(0, 1), 1);
        idle(12);
        chk(n_rd == rb + 8, "R10 returned words", 64'(n_rd - rb), 8);
        for (int i = 0; i < 8; i++)
            chk(rd_log[rb+i] === {rdat(i / 2, i % 2), 1'((i % 2) == 1)}, "R9 return order",
                64'(rd_log[rb+i]), {rdat(i / 2, i % 2), 1'((i % 2) == 1)});
        chk(usr_cmd_rdy === 1'b1, "R1 slots released", 64'(usr_cmd_rdy), 1);
    endtask

    initial begin
        #100us;
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1;
        idle(1);
        t_reset();
        t_read_split();
        t_write_before();
        t_write_after();
        t_queue_full();
        t_read_reorder();
        idle(2);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule